// File: doc/BRIEF.md
# Supervisor Virtualization Trap Guard

This block is the privileged-control slice of a small 32-bit hart. It holds the machine status word and the address-translation control word. For each decoded operation it decides whether a supervisor-level request must be turned into an illegal-instruction trap, so that a machine-level monitor can virtualize the supervisor. The operations are a CSR read or write, a supervisor return, wait-for-interrupt and an address-translation fence. The decision depends on three trap-enable bits in the status word, on the current privilege level and on a strap that says whether the hart follows the newer privileged rules.

Decode raises at most one of the strobes `csr_rd_i`/`csr_wr_i` (the pair may be raised together), `sret_i`, `wfi_i` and `sfence_i` in any cycle. Every output is registered and reflects the operation presented in the previous cycle. There is no valid/ready handshake, because each strobe is a single-cycle event that the block always accepts, so it never applies back-pressure. Status word layout: SIE=1, MIE=3, SPIE=5, MPIE=7, SPP=8, MPP=12:11, FS=14:13, MPRV=17, SUM=18, MXR=19, TVM=20, TW=21, TSR=22. Translation word layout: MODE=31 (0 bare, 1 paged), ASID=30:22, PPN=21:0. Privilege codes: U=0, S=1, M=3. The status CSR is at 0x300 and the translation CSR is at 0x180.

Top module: `sv_trap_guard`

## Requirements
- R1: A status write changes only bits 1,3,5,7,8,11-14,17-22 (mask 0x007E79AA). All other bits keep their value, which is zero.
- R2: A status write whose MPP field is 2, or is 0 when `SUPPORT_U`=0, leaves MPP unchanged while the other writable bits still update.
- R3: With `mmu_en_i`=0, a translation-word read returns 0, a write is dropped and neither one traps.
- R4: With the newer rules, privilege S and TVM=1, a read or write of the translation word traps. The read data is 0 and the stored value does not change.
- R5: A translation write takes effect only if its MODE is supported (paged only when `SUPPORT_SV32`=1) and the value differs from the stored one. `tlb_flush_o` pulses in the same cycle the new value becomes visible.
- R6: SRET at privilege S with TSR=1 traps. At M or U it does not.
- R7: WFI at privilege S with TW=1 traps and leaves `halt_o` low. Otherwise WFI sets `halt_o`, which stays high until `wake_i` is seen (wake wins over a simultaneous WFI).
- R8: SFENCE at privilege S with TVM=1 traps without a flush. Otherwise it pulses `tlb_flush_o`.
- R9: With `spec_v110_i`=0 no operation ever traps.
- R10: Privilege M is never trapped by TVM, TSR or TW.
- R11: `illegal_o` is high for exactly the cycle after a trapping operation. `cause_o` is 2 while it is high and 0 otherwise.
- R12: After reset the status word is 0x00001800 (MPP=M), the translation word is 0 and all pulse outputs and `halt_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| spec_v110_i | input | 1 | 1 when the newer privileged rules apply |
| mmu_en_i | input | 1 | Address translation hardware present |
| csr_rd_i | input | 1 | CSR read strobe |
| csr_wr_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| sret_i | input | 1 | Supervisor return strobe |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| sfence_i | input | 1 | Translation fence strobe |
| wake_i | input | 1 | Ends a halt |
| illegal_o | output | 1 | Illegal-instruction pulse |
| cause_o | output | 4 | Trap cause, 2 with the pulse |
| csr_rdata_o | output | 32 | Read data, valid the cycle after a read |
| tlb_flush_o | output | 1 | Translation cache flush pulse |
| halt_o | output | 1 | Halt request |

## Verification
The bench builds two instances side by side. The default one supports user mode and paged translation. The second has `SUPPORT_U`=0 and `SUPPORT_SV32`=0. With the second instance, a write of MPP=0 must be refused and a paged translation write must be dropped without a flush. The default build cannot reach either path. Both instances receive the same stimulus, so each rejection is checked against an acceptance in the same cycle.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int DW      = 32;
  localparam int AW      = 12;
  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 4'd2;

  localparam logic [AW-1:0] ADDR_STATUS = 12'h300;
  localparam logic [AW-1:0] ADDR_ATP    = 12'h180;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int B_SIE = 1, B_MIE = 3, B_SPIE = 5, B_MPIE = 7, B_SPP = 8;
  localparam int B_MPP_LO = 11, B_FS_LO = 13;
  localparam int B_MPRV = 17, B_SUM = 18, B_MXR = 19;
  localparam int B_TVM = 20, B_TW = 21, B_TSR = 22;
  localparam int B_MODE = 31;

  function automatic logic [DW-1:0] status_wmask();
    logic [DW-1:0] m;
    m = '0;
    m[B_SIE] = 1'b1; m[B_MIE] = 1'b1; m[B_SPIE] = 1'b1; m[B_MPIE] = 1'b1;
    m[B_SPP] = 1'b1; m[B_MPP_LO +: 2] = 2'b11; m[B_FS_LO +: 2] = 2'b11;
    m[B_MPRV] = 1'b1; m[B_SUM] = 1'b1; m[B_MXR] = 1'b1;
    m[B_TVM] = 1'b1; m[B_TW] = 1'b1; m[B_TSR] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tg_status.sv
module tg_status
  import tg_pkg::*;
#(
  parameter bit SUPPORT_U = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status
);
  localparam logic [DW-1:0] WMASK = status_wmask();
  localparam logic [DW-1:0] RST_VAL = DW'(PRIV_M) << B_MPP_LO;

  logic [1:0]    req_mpp;
  logic          mpp_ok;
  logic [DW-1:0] nxt;

  assign req_mpp = wdata[B_MPP_LO +: 2];

  generate
    if (SUPPORT_U) begin : g_with_user
      assign mpp_ok = (req_mpp != 2'd2);
    end else begin : g_no_user
      assign mpp_ok = (req_mpp == PRIV_S) || (req_mpp == PRIV_M);
    end
  endgenerate

  always_comb begin
    nxt = (status & ~WMASK) | (wdata & WMASK);
    if (!mpp_ok) nxt[B_MPP_LO +: 2] = status[B_MPP_LO +: 2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     status <= RST_VAL;
    else if (wr_en) status <= nxt;
  end
endmodule

// File: rtl/tg_atp.sv
module tg_atp
  import tg_pkg::*;
#(
  parameter bit SUPPORT_SV32 = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] atp,
  output logic          applied
);
  localparam logic [DW-1:0] FIELDS = '1;

  logic mode_ok;
  logic differs;

  generate
    if (SUPPORT_SV32) begin : g_paged
      assign mode_ok = 1'b1;
    end else begin : g_bare_only
      assign mode_ok = ~wdata[B_MODE];
    end
  endgenerate

  assign differs = |((wdata ^ atp) & FIELDS);
  assign applied = wr_req && mode_ok && differs;

  always_ff @(posedge clk) begin
    if (!rst_n)       atp <= '0;
    else if (applied) atp <= wdata;
  end
endmodule

// File: rtl/tg_gate.sv
module tg_gate
  import tg_pkg::*;
(
  input  logic [1:0]    priv,
  input  logic          spec_new,
  input  logic          mmu_en,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] atp,
  input  logic          csr_rd,
  input  logic          csr_wr,
  input  logic [AW-1:0] addr,
  input  logic          sret,
  input  logic          wfi,
  input  logic          sfence,
  output logic          trap,
  output logic          status_wr,
  output logic          atp_wr,
  output logic          halt_set,
  output logic          fence_flush,
  output logic [DW-1:0] rd_value
);
  logic in_s;
  logic tvm_hit;
  logic hit_atp;
  logic trap_atp, trap_sret, trap_wfi, trap_fence;

  assign in_s    = spec_new && (priv == PRIV_S);
  assign tvm_hit = in_s && status[B_TVM];
  assign hit_atp = (addr == ADDR_ATP) && (csr_rd || csr_wr);

  assign trap_atp   = hit_atp && mmu_en && tvm_hit;
  assign trap_sret  = sret && in_s && status[B_TSR];
  assign trap_wfi   = wfi && in_s && status[B_TW];
  assign trap_fence = sfence && tvm_hit;
  assign trap       = trap_atp || trap_sret || trap_wfi || trap_fence;

  assign status_wr   = csr_wr && (addr == ADDR_STATUS);
  assign atp_wr      = csr_wr && (addr == ADDR_ATP) && mmu_en && !tvm_hit;
  assign halt_set    = wfi && !trap_wfi;
  assign fence_flush = sfence && !trap_fence;

  always_comb begin
    rd_value = '0;
    if (csr_rd) begin
      if (addr == ADDR_STATUS) rd_value = status;
      else if (addr == ADDR_ATP && mmu_en && !trap_atp) rd_value = atp;
    end
  end
endmodule

// File: rtl/tg_halt.sv
module tg_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic wake,
  output logic halt
);
  always_ff @(posedge clk) begin
    if (!rst_n)    halt <= 1'b0;
    else if (wake) halt <= 1'b0;
    else if (set)  halt <= 1'b1;
  end
endmodule

// File: rtl/sv_trap_guard.sv
module sv_trap_guard
  import tg_pkg::*;
#(
  parameter bit SUPPORT_U    = 1'b1,
  parameter bit SUPPORT_SV32 = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         priv_i,
  input  logic               spec_v110_i,
  input  logic               mmu_en_i,
  input  logic               csr_rd_i,
  input  logic               csr_wr_i,
  input  logic [AW-1:0]      csr_addr_i,
  input  logic [DW-1:0]      csr_wdata_i,
  input  logic               sret_i,
  input  logic               wfi_i,
  input  logic               sfence_i,
  input  logic               wake_i,
  output logic               illegal_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [DW-1:0]      csr_rdata_o,
  output logic               tlb_flush_o,
  output logic               halt_o
);
  logic [DW-1:0] status_q, atp_q, rd_value;
  logic trap, status_wr, atp_wr, atp_applied, halt_set, fence_flush;

  tg_gate u_gate (
    .priv(priv_i), .spec_new(spec_v110_i), .mmu_en(mmu_en_i),
    .status(status_q), .atp(atp_q),
    .csr_rd(csr_rd_i), .csr_wr(csr_wr_i), .addr(csr_addr_i),
    .sret(sret_i), .wfi(wfi_i), .sfence(sfence_i),
    .trap(trap), .status_wr(status_wr), .atp_wr(atp_wr),
    .halt_set(halt_set), .fence_flush(fence_flush), .rd_value(rd_value)
  );

  tg_status #(.SUPPORT_U(SUPPORT_U)) u_status (
    .clk(clk), .rst_n(rst_n), .wr_en(status_wr),
    .wdata(csr_wdata_i), .status(status_q)
  );

  tg_atp #(.SUPPORT_SV32(SUPPORT_SV32)) u_atp (
    .clk(clk), .rst_n(rst_n), .wr_req(atp_wr),
    .wdata(csr_wdata_i), .atp(atp_q), .applied(atp_applied)
  );

  tg_halt u_halt (
    .clk(clk), .rst_n(rst_n), .set(halt_set), .wake(wake_i), .halt(halt_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegal_o   <= 1'b0;
      cause_o     <= '0;
      csr_rdata_o <= '0;
      tlb_flush_o <= 1'b0;
    end else begin
      illegal_o   <= trap;
      cause_o     <= trap ? CAUSE_ILLEGAL : '0;
      csr_rdata_o <= rd_value;
      tlb_flush_o <= atp_applied || fence_flush;
    end
  end
endmodule

// File: rtl/tg_checker.sv
module tg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  priv_i,
  input logic        spec_v110_i,
  input logic        wake_i,
  input logic        illegal_o,
  input logic [3:0]  cause_o,
  input logic [31:0] csr_rdata_o,
  input logic        tlb_flush_o,
  input logic        halt_o,
  input logic [31:0] status_q,
  input logic [31:0] atp_q
);
  a_r11_cause_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> cause_o == 4'd2);
  a_r11_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal_o |-> cause_o == 4'd0);
  a_r9_old_rules_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_v110_i |=> !illegal_o);
  a_r10_machine_free: assert property (@(posedge clk) disable iff (!rst_n)
    priv_i == 2'd3 |=> !illegal_o);
  a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !wake_i) |=> halt_o);
  a_r7_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> !halt_o);
  a_r5_change_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    (atp_q != $past(atp_q)) |-> tlb_flush_o);
  a_r4_trap_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> csr_rdata_o == 32'd0);
  a_r2_mpp_legal: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[12:11] != 2'd2);
endmodule

bind sv_trap_guard tg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .spec_v110_i(spec_v110_i),
  .wake_i(wake_i), .illegal_o(illegal_o), .cause_o(cause_o),
  .csr_rdata_o(csr_rdata_o), .tlb_flush_o(tlb_flush_o), .halt_o(halt_o),
  .status_q(status_q), .atp_q(atp_q)
);

// File: tb/tb_sv_trap_guard.sv
module tb_sv_trap_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] priv = 2'd3;
  logic spec = 1'b1, mmu = 1'b1;
  logic rd = 0, wr = 0, sret = 0, wfi = 0, sfence = 0, wake = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;

  logic ill_a, ill_b, fl_a, fl_b, h_a, h_b;
  logic [3:0] c_a, c_b;
  logic [31:0] rd_a, rd_b;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sv_trap_guard dut (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .spec_v110_i(spec), .mmu_en_i(mmu),
    .csr_rd_i(rd), .csr_wr_i(wr), .csr_addr_i(addr), .csr_wdata_i(wdata),
    .sret_i(sret), .wfi_i(wfi), .sfence_i(sfence), .wake_i(wake),
    .illegal_o(ill_a), .cause_o(c_a), .csr_rdata_o(rd_a),
    .tlb_flush_o(fl_a), .halt_o(h_a)
  );

  sv_trap_guard #(.SUPPORT_U(1'b0), .SUPPORT_SV32(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .spec_v110_i(spec), .mmu_en_i(mmu),
    .csr_rd_i(rd), .csr_wr_i(wr), .csr_addr_i(addr), .csr_wdata_i(wdata),
    .sret_i(sret), .wfi_i(wfi), .sfence_i(sfence), .wake_i(wake),
    .illegal_o(ill_b), .cause_o(c_b), .csr_rdata_o(rd_b),
    .tlb_flush_o(fl_b), .halt_o(h_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    rd = 0; wr = 0; sret = 0; wfi = 0; sfence = 0; wake = 0;
  endtask

  task automatic csr_read(input logic [1:0] p, input logic [11:0] a);
    priv = p; addr = a; rd = 1; step();
  endtask

  task automatic csr_write(input logic [1:0] p, input logic [11:0] a, input logic [31:0] d);
    priv = p; addr = a; wdata = d; wr = 1; step();
  endtask

  task automatic do_sret(input logic [1:0] p);   priv = p; sret = 1;   step(); endtask
  task automatic do_wfi(input logic [1:0] p);    priv = p; wfi = 1;    step(); endtask
  task automatic do_sfence(input logic [1:0] p); priv = p; sfence = 1; step(); endtask
  task automatic do_wake();                      wake = 1;             step(); endtask

  task automatic t_reset();
    chk("R12 illegal", ill_a, 0);
    chk("R12 halt", h_a, 0);
    chk("R12 flush", fl_a, 0);
    csr_read(2'd3, 12'h300);
    chk("R12 status", rd_a, 32'h0000_1800);
    csr_read(2'd3, 12'h180);
    chk("R12 atp", rd_a, 32'h0);
  endtask

  task automatic t_mask();
    csr_write(2'd3, 12'h300, 32'hFFFF_FFFF);
    csr_read(2'd3, 12'h300);
    chk("R1 all ones", rd_a, 32'h007E_79AA);
    chk("R1 all ones b", rd_b, 32'h007E_79AA);
    csr_write(2'd3, 12'h300, 32'h0);
    csr_read(2'd3, 12'h300);
    chk("R1 zeros", rd_a, 32'h0);
    chk("R2 mpp0 refused b", rd_b, 32'h0000_1800);
  endtask

  task automatic t_mpp();
    csr_write(2'd3, 12'h300, 32'h0000_1002);
    csr_read(2'd3, 12'h300);
    chk("R2 mpp2 refused", rd_a, 32'h0000_0002);
    chk("R2 mpp2 refused b", rd_b, 32'h0000_1802);
    csr_write(2'd3, 12'h300, 32'h0000_0800);
    csr_read(2'd3, 12'h300);
    chk("R2 mpp1 taken", rd_a, 32'h0000_0800);
    chk("R2 mpp1 taken b", rd_b, 32'h0000_0800);
    csr_write(2'd3, 12'h300, 32'h0000_1800);
  endtask

  task automatic t_atp();
    csr_write(2'd3, 12'h180, 32'h8000_1234);
    chk("R5 paged flush", fl_a, 1);
    chk("R5 paged dropped b", fl_b, 0);
    csr_read(2'd3, 12'h180);
    chk("R5 paged stored", rd_a, 32'h8000_1234);
    chk("R5 paged dropped b", rd_b, 32'h0);
    csr_write(2'd3, 12'h180, 32'h8000_1234);
    chk("R5 same value no flush", fl_a, 0);
    csr_write(2'd3, 12'h180, 32'h0000_5678);
    chk("R5 bare flush", fl_a, 1);
    chk("R5 bare flush b", fl_b, 1);
    csr_read(2'd3, 12'h180);
    chk("R5 bare stored", rd_a, 32'h0000_5678);
    chk("R5 bare stored b", rd_b, 32'h0000_5678);
  endtask

  task automatic t_tvm();
    csr_write(2'd3, 12'h300, 32'h0010_1800);
    csr_read(2'd1, 12'h180);
    chk("R4 read traps", ill_a, 1);
    chk("R11 cause", c_a, 4'd2);
    chk("R4 no data", rd_a, 32'h0);
    step();
    chk("R11 single pulse", ill_a, 0);
    chk("R11 cause idle", c_a, 4'd0);
    csr_write(2'd1, 12'h180, 32'h8000_0001);
    chk("R4 write traps", ill_a, 1);
    chk("R4 write no flush", fl_a, 0);
    csr_read(2'd3, 12'h180);
    chk("R4 value kept", rd_a, 32'h0000_5678);
    chk("R10 machine read ok", ill_a, 0);
    do_sfence(2'd1);
    chk("R8 fence traps", ill_a, 1);
    chk("R8 fence no flush", fl_a, 0);
    do_sfence(2'd3);
    chk("R10 fence machine", ill_a, 0);
    chk("R8 fence flush", fl_a, 1);
    do_sfence(2'd0);
    chk("R8 fence user flush", fl_a, 1);
  endtask

  task automatic t_old_rules();
    spec = 0;
    csr_write(2'd3, 12'h300, 32'h0070_1800);
    csr_read(2'd1, 12'h180);
    chk("R9 read no trap", ill_a, 0);
    chk("R9 read data", rd_a, 32'h0000_5678);
    do_sfence(2'd1);
    chk("R9 fence flush", fl_a, 1);
    do_sret(2'd1);
    chk("R9 sret no trap", ill_a, 0);
    do_wfi(2'd1);
    chk("R9 wfi no trap", ill_a, 0);
    chk("R9 wfi halts", h_a, 1);
    do_wake();
    chk("R7 wake", h_a, 0);
    spec = 1;
  endtask

  task automatic t_tsr();
    csr_write(2'd3, 12'h300, 32'h0040_1800);
    do_sret(2'd1);
    chk("R6 sret S traps", ill_a, 1);
    do_sret(2'd3);
    chk("R6 sret M ok", ill_a, 0);
    do_sret(2'd0);
    chk("R6 sret U ok", ill_a, 0);
  endtask

  task automatic t_tw();
    csr_write(2'd3, 12'h300, 32'h0020_1800);
    do_wfi(2'd1);
    chk("R7 wfi S traps", ill_a, 1);
    chk("R7 no halt on trap", h_a, 0);
    do_wfi(2'd0);
    chk("R7 wfi U halts", h_a, 1);
    for (int i = 0; i < 3; i++) step();
    chk("R7 halt held", h_a, 1);
    do_wake();
    chk("R7 wake clears", h_a, 0);
    do_wfi(2'd3);
    chk("R10 wfi M halts", h_a, 1);
    chk("R10 wfi M no trap", ill_a, 0);
    priv = 2'd3; wfi = 1; wake = 1; step();
    chk("R7 wake wins", h_a, 0);
  endtask

  task automatic t_no_mmu();
    csr_write(2'd3, 12'h300, 32'h0010_1800);
    mmu = 0;
    csr_read(2'd1, 12'h180);
    chk("R3 read zero", rd_a, 32'h0);
    chk("R3 read no trap", ill_a, 0);
    csr_write(2'd1, 12'h180, 32'h0000_1111);
    chk("R3 write no trap", ill_a, 0);
    chk("R3 write no flush", fl_a, 0);
    mmu = 1;
    csr_read(2'd3, 12'h180);
    chk("R3 write dropped", rd_a, 32'h0000_5678);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_mask();
    t_mpp();
    t_atp();
    t_tvm();
    t_old_rules();
    t_tsr();
    t_tw();
    t_no_mmu();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule